// File: doc/BRIEF.md
# Serial Memory Target Protocol Engine

This block is the two-wire-bus front end of a 128-byte serial memory. It samples the bus clock and data lines with the system clock, recognises Start and Stop conditions, and checks the first byte of each transfer against a fixed device code and three strap inputs. When the byte matches, the engine either takes a word address into its address pointer or sends bytes from its internal register array. Sending continues for as long as the bus master acknowledges each byte.

Write data does not go into the array directly. Each received data byte is handed to a separate page-write controller together with its target address, and a Stop that ends a write is passed on as a one-cycle event. That controller raises a busy flag while it programs. It commits the bytes through the array's load port. While the flag is high the engine acknowledges nothing, so a master can poll for completion.

The data line is open drain. The engine only ever asserts an enable that pulls the line low.

Top module: `serMemTarget`

## Requirements
- R1: After reset the data-line pull enable is low, neither write strobe is active and the address pointer is 0.
- R2: A control byte (sent MSB first) is acknowledged by pulling the data line low during the ninth clock pulse only when bits 7:4 equal 1010 and bits 3:1 equal `strapSel`. Any other control byte gets no acknowledge, and every later byte is ignored (never acknowledged) until the next Start.
- R3: In a write (bit 0 of the control byte = 0), the next byte is acknowledged and its low 7 bits are loaded into the pointer; bit 7 is ignored. Each later data byte is acknowledged and presented for one cycle on `wrByteValid` with `wrByteAddr` = pointer and `wrByteData` = byte.
- R4: After each write data byte only the low 4 pointer bits count up, so writes wrap inside a 16-byte page (3Fh is followed by 30h).
- R5: A Stop after at least one write data byte pulses `wrStop` once. A Stop or repeated Start after only the address phase gives no `wrStop`, but the pointer keeps the new address.
- R6: A read (bit 0 = 1) sends the array byte at the pointer, MSB first, starting at the falling clock edge that ends the acknowledge. The pointer advances by one per byte sent, so a read without an address phase continues where the last access stopped.
- R7: A master acknowledge after a sent byte makes the engine send the next byte; the pointer wraps from 7Fh to 00h. A master non-acknowledge releases the line, and the engine drives nothing until the next Start.
- R8: If `wrBusy` is high when the last bit of a control, address or data byte is received, that byte is not acknowledged and the engine waits for a Start.
- R9: A Start in the middle of a byte restarts control-byte decode. A Stop in the middle of a byte returns to idle. Neither changes the pointer or raises `wrStop` for an unfinished write.
- R10: The pull enable changes only after a detected falling edge of the bus clock, so it is stable while the clock is high. It is released after any Start or Stop.
- R11: `memWrEn` writes `memWrData` into the array at `memWrAddr` on the next rising system clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level (wired value) |
| strapSel | input | 3 | Device select straps compared with control byte bits 3:1 |
| sdaDriveLow | output | 1 | 1 pulls the data line low |
| wrBusy | input | 1 | Page-write controller is programming |
| wrByteValid | output | 1 | One-cycle strobe for a received write data byte |
| wrByteAddr | output | 7 | Target address of the presented write byte |
| wrByteData | output | 8 | Presented write data byte |
| wrStop | output | 1 | One-cycle strobe: a write with data ended with Stop |
| memWrEn | input | 1 | Array load enable from the page-write controller |
| memWrAddr | input | 7 | Array load address |
| memWrData | input | 8 | Array load data |

## Verification
The bench tries all 256 control byte values against fixed straps. This separates a code or strap mismatch from a match, and a read from a write. Random reads at addresses spread across the array, some with bit 7 of the address byte set, show that the pointer is loaded and that a repeated Start creates no programming event. A sequential read across 7Fh and a page write across a page boundary separate the two ways the pointer counts. A busy-flag poll and transfers cut off mid-byte by a Start or a Stop show which events end a transfer without side effects.

// File: rtl/serMemPkg.sv
package serMemPkg;
  localparam int BYTE_W = 8;
  localparam int STRAP_W = 3;
  localparam int CODE_W = 4;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_ACKWAIT,
    ST_ACKHOLD,
    ST_TX,
    ST_MACK
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic clrBits;
    logic loadPtr;
    logic stepPage;
    logic emitByte;
    logic loadTx;
    logic shiftTx;
  } pathCtl_t;
endpackage

// File: rtl/serMemLineSync.sv
module serMemLineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEvt,
  output logic stopEvt
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sclPipe;
  logic [LAST:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  generate
    if (STAGES > 1) begin : gMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[LAST-1:0], sclIn};
          sdaPipe <= {sdaPipe[LAST-1:0], sdaIn};
        end
      end
    end else begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclPipe[LAST];
      sdaPrev <= sdaPipe[LAST];
    end
  end

  assign sclS     = sclPipe[LAST];
  assign sdaS     = sdaPipe[LAST];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startEvt = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEvt  = sclS & sclPrev & ~sdaPrev & sdaS;
endmodule

// File: rtl/serMemPath.sv
module serMemPath
  import serMemPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic              sdaS,
  input  logic              memWrEn,
  input  logic [ADDR_W-1:0] memWrAddr,
  input  logic [BYTE_W-1:0] memWrData,
  output logic [BYTE_W-1:0] rxByte,
  output logic              bitLast,
  output logic              txNextBit,
  output logic              rdMsb,
  output logic [ADDR_W-1:0] wrByteAddr,
  output logic [BYTE_W-1:0] wrByteData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_W) - 1);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0]    memArr [DEPTH];
  logic [BYTE_W-2:0]    rxShift;
  logic [BYTE_W-2:0]    txShift;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [ADDR_W-1:0]    ptr;
  logic [ADDR_W-1:0]    ptrInc;
  logic [ADDR_W-1:0]    ptrPageStep;
  logic [BYTE_W-1:0]    rdByte;

  assign rxByte      = {rxShift, sdaS};
  assign bitLast     = (bitCnt == LAST_BIT);
  assign rdByte      = memArr[ptr];
  assign rdMsb       = rdByte[BYTE_W-1];
  assign txNextBit   = txShift[BYTE_W-2];
  assign ptrInc      = ptr + 1'b1;
  assign ptrPageStep = (ptr & ~PAGE_MASK) | (ptrInc & PAGE_MASK);

  always_ff @(posedge clk) begin
    if (memWrEn) memArr[memWrAddr] <= memWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift    <= '0;
      txShift    <= '0;
      bitCnt     <= '0;
      ptr        <= '0;
      wrByteAddr <= '0;
      wrByteData <= '0;
    end else begin
      if (ctl.clrBits) bitCnt <= '0;
      else if (ctl.shiftIn || ctl.shiftTx) bitCnt <= bitCnt + 1'b1;

      if (ctl.shiftIn) rxShift <= rxByte[BYTE_W-2:0];

      if (ctl.loadPtr) ptr <= rxByte[ADDR_W-1:0];
      else if (ctl.stepPage) ptr <= ptrPageStep;
      else if (ctl.loadTx) ptr <= ptrInc;

      if (ctl.loadTx) txShift <= rdByte[BYTE_W-2:0];
      else if (ctl.shiftTx) txShift <= {txShift[BYTE_W-3:0], 1'b0};

      if (ctl.emitByte) begin
        wrByteAddr <= ptr;
        wrByteData <= rxByte;
      end
    end
  end
endmodule

// File: rtl/serMemCtrl.sv
module serMemCtrl
  import serMemPkg::*;
#(
  parameter logic [CODE_W-1:0] CTRL_CODE = 4'b1010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic               startEvt,
  input  logic               stopEvt,
  input  logic               sdaS,
  input  logic [STRAP_W-1:0] strapSel,
  input  logic               wrBusy,
  input  logic [BYTE_W-1:0]  rxByte,
  input  logic               bitLast,
  input  logic               txNextBit,
  input  logic               rdMsb,
  output pathCtl_t           ctl,
  output logic               sdaDriveLow,
  output logic               wrByteValid,
  output logic               wrStop
);
  engState_t state, stateN;
  engState_t afterAck, afterAckN;
  logic oeN;
  logic dataSeen, dataSeenN;
  logic validN, stopN;
  logic ctrlMatch;

  assign ctrlMatch = (rxByte[BYTE_W-1 -: CODE_W] == CTRL_CODE) &&
                     (rxByte[STRAP_W:1] == strapSel);

  always_comb begin
    stateN    = state;
    afterAckN = afterAck;
    oeN       = sdaDriveLow;
    dataSeenN = dataSeen;
    validN    = 1'b0;
    stopN     = 1'b0;
    ctl       = '0;
    if (stopEvt) begin
      stateN    = ST_IDLE;
      oeN       = 1'b0;
      stopN     = dataSeen;
      dataSeenN = 1'b0;
    end else if (startEvt) begin
      stateN      = ST_CTRL;
      oeN         = 1'b0;
      dataSeenN   = 1'b0;
      ctl.clrBits = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_CTRL: if (sclRise) begin
          ctl.shiftIn = 1'b1;
          if (bitLast) begin
            if (ctrlMatch && !wrBusy) begin
              stateN    = ST_ACKWAIT;
              afterAckN = rxByte[0] ? ST_TX : ST_ADDR;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        ST_ADDR: if (sclRise) begin
          ctl.shiftIn = 1'b1;
          if (bitLast) begin
            if (!wrBusy) begin
              ctl.loadPtr = 1'b1;
              stateN      = ST_ACKWAIT;
              afterAckN   = ST_WDATA;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        ST_WDATA: if (sclRise) begin
          ctl.shiftIn = 1'b1;
          if (bitLast) begin
            if (!wrBusy) begin
              ctl.emitByte = 1'b1;
              ctl.stepPage = 1'b1;
              validN       = 1'b1;
              dataSeenN    = 1'b1;
              stateN       = ST_ACKWAIT;
              afterAckN    = ST_WDATA;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        ST_ACKWAIT: if (sclFall) begin
          oeN    = 1'b1;
          stateN = ST_ACKHOLD;
        end
        ST_ACKHOLD: if (sclFall) begin
          ctl.clrBits = 1'b1;
          if (afterAck == ST_TX) begin
            ctl.loadTx = 1'b1;
            oeN        = ~rdMsb;
            stateN     = ST_TX;
          end else begin
            oeN    = 1'b0;
            stateN = afterAck;
          end
        end
        ST_TX: if (sclFall) begin
          if (bitLast) begin
            oeN    = 1'b0;
            stateN = ST_MACK;
          end else begin
            ctl.shiftTx = 1'b1;
            oeN         = ~txNextBit;
          end
        end
        ST_MACK: if (sclRise) begin
          if (sdaS) begin
            stateN = ST_IDLE;
          end else begin
            stateN    = ST_ACKHOLD;
            afterAckN = ST_TX;
          end
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      afterAck    <= ST_IDLE;
      sdaDriveLow <= 1'b0;
      dataSeen    <= 1'b0;
      wrByteValid <= 1'b0;
      wrStop      <= 1'b0;
    end else begin
      state       <= stateN;
      afterAck    <= afterAckN;
      sdaDriveLow <= oeN;
      dataSeen    <= dataSeenN;
      wrByteValid <= validN;
      wrStop      <= stopN;
    end
  end
endmodule

// File: rtl/serMemTarget.sv
module serMemTarget
  import serMemPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] CTRL_CODE = 4'b1010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapSel,
  output logic               sdaDriveLow,
  input  logic               wrBusy,
  output logic               wrByteValid,
  output logic [ADDR_W-1:0]  wrByteAddr,
  output logic [BYTE_W-1:0]  wrByteData,
  output logic               wrStop,
  input  logic               memWrEn,
  input  logic [ADDR_W-1:0]  memWrAddr,
  input  logic [BYTE_W-1:0]  memWrData
);
  logic sclS, sdaS, sclRise, sclFall, startEvt, stopEvt;
  logic [BYTE_W-1:0] rxByte;
  logic bitLast, txNextBit, rdMsb;
  pathCtl_t ctl;

  serMemLineSync #(.STAGES(SYNC_STAGES)) syncI (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startEvt(startEvt), .stopEvt(stopEvt)
  );

  serMemCtrl #(.CTRL_CODE(CTRL_CODE)) ctrlI (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEvt(startEvt), .stopEvt(stopEvt), .sdaS(sdaS),
    .strapSel(strapSel), .wrBusy(wrBusy), .rxByte(rxByte),
    .bitLast(bitLast), .txNextBit(txNextBit), .rdMsb(rdMsb),
    .ctl(ctl), .sdaDriveLow(sdaDriveLow), .wrByteValid(wrByteValid),
    .wrStop(wrStop)
  );

  serMemPath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) pathI (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaS(sdaS),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .rxByte(rxByte), .bitLast(bitLast), .txNextBit(txNextBit),
    .rdMsb(rdMsb), .wrByteAddr(wrByteAddr), .wrByteData(wrByteData)
  );
endmodule

// File: rtl/serMemChecker.sv
module serMemChecker (
  input logic clk,
  input logic rstN,
  input logic sclS,
  input logic startEvt,
  input logic stopEvt,
  input logic sdaDriveLow,
  input logic wrByteValid,
  input logic wrStop
);
  // R10: pull enable only moves while the synchronized clock is low
  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $changed(sdaDriveLow) |-> !$past(sclS));

  // R9 / R10: Stop releases the line
  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    stopEvt |=> !sdaDriveLow);

  // R9 / R10: Start releases the line
  assert_start_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    startEvt |=> !sdaDriveLow);

  // R5: the end-of-write event is a single cycle
  assert_wrstop_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrStop |=> !wrStop);

  // R3: a data byte strobe never coincides with the end-of-write event
  assert_byte_not_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrByteValid |-> !wrStop);
endmodule

bind serMemTarget serMemChecker chkI (
  .clk(clk), .rstN(rstN), .sclS(sclS), .startEvt(startEvt),
  .stopEvt(stopEvt), .sdaDriveLow(sdaDriveLow),
  .wrByteValid(wrByteValid), .wrStop(wrStop)
);

// File: tb/serMemTarget_tb_top.sv
module serMemTarget_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic wrBusy = 1'b0;
  logic memWrEn = 1'b0;
  logic [6:0] memWrAddr = '0;
  logic [7:0] memWrData = '0;
  logic [2:0] strap = 3'b101;
  logic sdaDriveLow, wrByteValid, wrStop;
  logic [6:0] wrByteAddr;
  logic [7:0] wrByteData;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaDriveLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  serMemTarget dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .strapSel(strap), .sdaDriveLow(sdaDriveLow), .wrBusy(wrBusy),
    .wrByteValid(wrByteValid), .wrByteAddr(wrByteAddr),
    .wrByteData(wrByteData), .wrStop(wrStop), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  int nChecks = 0;
  int nFail = 0;
  int unstable = 0;
  int stopCount = 0;
  int capN = 0;
  logic [6:0] capA [16];
  logic [7:0] capD [16];
  logic [7:0] model [128];
  int eptr = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (rstN) begin
      if (wrByteValid && capN < 16) begin
        capA[capN] <= wrByteAddr;
        capD[capN] <= wrByteData;
        capN <= capN + 1;
      end
      if (wrStop) stopCount <= stopCount + 1;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitPulse(input logic d, output logic s);
    logic s1;
    sdaM = d;
    waitClk(Q);
    sclM = 1'b1;
    waitClk(1);
    s1 = sdaLine;
    waitClk(Q - 1);
    s = sdaLine;
    if (s1 != s) unstable++;
    sclM = 1'b0;
    waitClk(Q);
  endtask

  task automatic startC();
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic stopC();
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b1; waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bitPulse(b[i], s);
    bitPulse(1'b1, s);
    ack = ~s;
  endtask

  task automatic readByte(input logic mack, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bitPulse(1'b1, s);
      b = {b[6:0], s};
    end
    bitPulse(~mack, s);
  endtask

  task automatic setAddr(input logic [7:0] a);
    logic ack;
    startC();
    sendByte({4'hA, strap, 1'b0}, ack);
    check("R2 write control ack", ack, 1);
    sendByte(a, ack);
    check("R3 address ack", ack, 1);
    eptr = a[6:0];
  endtask

  task automatic readAt(input logic [7:0] a, output logic [7:0] d);
    logic ack;
    setAddr(a);
    startC();
    sendByte({4'hA, strap, 1'b1}, ack);
    check("R2 read control ack", ack, 1);
    readByte(1'b0, d);
    stopC();
    eptr = (eptr + 1) & 127;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=expired expected=finished");
      summary();
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int stopBase;
    int capBase;
    int low;

    waitClk(4);
    check("R1 reset pull enable", sdaDriveLow, 0);
    check("R1 reset byte strobe", wrByteValid, 0);
    check("R1 reset stop strobe", wrStop, 0);
    rstN = 1'b1;
    waitClk(3);

    // R11: preload through the array load port
    for (int a = 0; a < 128; a++) begin
      memWrEn = 1'b1;
      memWrAddr = 7'(a);
      memWrData = pat(a);
      model[a] = pat(a);
      waitClk(1);
    end
    memWrEn = 1'b0;
    waitClk(2);

    // R1/R6/R11: current-address read from the reset pointer
    startC();
    sendByte({4'hA, strap, 1'b1}, ack);
    check("R2 first read ack", ack, 1);
    readByte(1'b0, d);
    check("R6 R1 R11 read at pointer 0", d, model[0]);
    stopC();
    eptr = 1;

    // R2: full control-byte sweep
    for (int b = 0; b < 256; b++) begin
      logic expAck;
      expAck = (b[7:4] == 4'hA) && (b[3:1] == strap);
      startC();
      sendByte(8'(b), ack);
      check("R2 control byte decode", ack, expAck);
      if (ack && b[0]) begin
        readByte(1'b0, d);
        check("R6 current address read", d, model[eptr]);
        eptr = (eptr + 1) & 127;
      end else if (!expAck && (b & 15) == 0) begin
        sendByte(8'h00, ack);
        check("R2 ignored after mismatch", ack, 0);
      end
      stopC();
    end
    check("R5 no stop event without data", stopCount, 0);

    // R3/R5/R6: random reads, address bit 7 ignored
    for (int a = 0; a < 128; a += 5) begin
      logic [7:0] ab;
      ab = 8'(a) | ((a & 1) != 0 ? 8'h80 : 8'h00);
      readAt(ab, d);
      check("R3 R6 random read", d, model[a]);
    end
    check("R5 repeated start gives no stop event", stopCount, 0);

    // R7: sequential read across 7Fh
    setAddr(8'h7D);
    startC();
    sendByte({4'hA, strap, 1'b1}, ack);
    check("R7 read ack", ack, 1);
    for (int i = 0; i < 5; i++) begin
      readByte(i < 4, d);
      check("R7 sequential byte", d, model[(16'h7D + i) & 127]);
    end
    low = 0;
    for (int i = 0; i < 9; i++) begin
      logic s;
      bitPulse(1'b1, s);
      if (!s) low++;
    end
    check("R7 line released after master nack", low, 0);
    stopC();
    startC();
    sendByte({4'hA, strap, 1'b1}, ack);
    readByte(1'b0, d);
    stopC();
    check("R6 continue after wrap", d, model[2]);

    // R3/R4/R5: page write crossing 3Fh
    capBase = capN;
    stopBase = stopCount;
    setAddr(8'h3E);
    for (int i = 0; i < 4; i++) begin
      sendByte(8'(8'hC0 + i), ack);
      check("R3 data byte ack", ack, 1);
    end
    stopC();
    waitClk(2);
    check("R5 stop event after data", stopCount - stopBase, 1);
    check("R3 byte strobe count", capN - capBase, 4);
    for (int i = 0; i < 4; i++) begin
      check("R4 page wrap address", capA[capBase + i], (16'h3E + i) % 16 + 16'h30);
      check("R3 presented data", capD[capBase + i], 16'hC0 + i);
    end

    // R8: busy polling, bench acts as page-write controller
    wrBusy = 1'b1;
    startC();
    sendByte({4'hA, strap, 1'b0}, ack);
    check("R8 no ack while busy", ack, 0);
    stopC();
    for (int i = 0; i < 4; i++) begin
      memWrEn = 1'b1;
      memWrAddr = capA[capBase + i];
      memWrData = capD[capBase + i];
      model[capA[capBase + i]] = capD[capBase + i];
      waitClk(1);
    end
    memWrEn = 1'b0;
    wrBusy = 1'b0;
    waitClk(2);
    startC();
    sendByte({4'hA, strap, 1'b0}, ack);
    check("R8 ack after busy clears", ack, 1);
    stopC();
    readAt(8'h30, d);
    check("R4 committed wrapped byte", d, 8'hC2);

    // R9: Start in the middle of an address byte
    readAt(8'h10, d);
    startC();
    sendByte({4'hA, strap, 1'b0}, ack);
    begin
      logic s;
      bitPulse(1'b1, s);
      bitPulse(1'b1, s);
      bitPulse(1'b0, s);
    end
    startC();
    sendByte({4'hA, strap, 1'b1}, ack);
    check("R9 control decode after mid-byte start", ack, 1);
    readByte(1'b0, d);
    stopC();
    check("R9 pointer kept after mid-byte start", d, model[8'h11]);

    // R9: Stop in the middle of a data byte
    stopBase = stopCount;
    setAddr(8'h50);
    begin
      logic s;
      for (int i = 0; i < 4; i++) bitPulse(1'b0, s);
    end
    stopC();
    check("R9 no stop event for unfinished byte", stopCount - stopBase, 0);
    startC();
    sendByte({4'hA, strap, 1'b1}, ack);
    readByte(1'b0, d);
    stopC();
    check("R9 read after mid-byte stop", d, model[8'h50]);

    check("R10 line stable while clock high", unstable, 0);

    done = 1;
    summary();
  end
endmodule